// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block produces the horizontal and vertical timing of a raster display from a small set of programmed parameters. Two position counters (pixel within a line, line within a frame) step on every pixel clock. From them the block derives display-enable, horizontal and vertical blanking, a CRT-style horizontal and vertical sync pair, and a flat-panel line and frame pulse pair. Each of the four pulses has its own polarity. The current pixel and line positions leave the block as outputs, and a status flag reports whether the frame is in its vertical non-display region.

Software writes the timing fields through a single-cycle address/data/write-enable port and can read them back through a separate combinational read port. Horizontal quantities are coarse: each is an 8-pixel multiple of a biased field. The horizontal sync start carries a fixed 2-pixel pull-in. Vertical quantities are whole lines with a +1 bias. Writes land in a pending copy, and the timing logic only picks them up at the start of the next frame. A frame in progress therefore never runs on a mix of old and new values.

Each axis is driven by a two-state sequencer. Its states are SEG_ACTIVE and SEG_BLANK. Transition ACT_DONE moves from SEG_ACTIVE to SEG_BLANK on the last active position. Transition WRAP moves from SEG_BLANK back to SEG_ACTIVE on the last position of the period, and resets the position to 0. The horizontal sequencer steps on every clock. The vertical sequencer steps only when the horizontal one takes WRAP. Reset puts both sequencers in SEG_ACTIVE at position 0.

Top module: `disp_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both counters go to 0, both sequencers go to SEG_ACTIVE, and all programmed fields clear to 0. With fields at 0, `de` reads 1 and every pulse reads inactive.
- R2: `pix_x` increments by one each clock and returns to 0 after HT−1, where HT = 8·(HA+1) + 8·(HB+1). HA is the 7-bit field at address 0 (bits 6:0). HB is the 5-bit field at address 1 (bits 4:0).
- R3: `line_y` changes only in the cycle where `pix_x` returns to 0. It advances by one there, and returns to 0 after VT−1, where VT = (VA+1) + (VB+1). VA is 10 bits: address 4 holds bits 7:0 and address 5 holds bits 9:8. VB is the 6-bit field at address 6 (bits 5:0).
- R4: `de` is 1 exactly when `pix_x` < 8·(HA+1) and `line_y` < VA+1. `hblank` is 1 exactly when `pix_x` ≥ 8·(HA+1). `vblank` is 1 exactly when `line_y` ≥ VA+1.
- R5: The horizontal sync window covers `pix_x` in [8·(HA+1) + 8·(HS+1) − 2, that start + 8·(HW+1)). HS is the 5-bit field at address 2 (bits 4:0). HW is the 4-bit field at address 3 (bits 3:0). A window running past HT−1 is cut off at the line end.
- R6: The vertical sync window covers `line_y` in [VA+1 + VS+1, that start + VW+1). VS is the 6-bit field at address 7 (bits 5:0). VW is the 3-bit field at address 8 (bits 2:0). A window running past VT−1 is cut off at the frame end.
- R7: Each pulse equals its window XOR its polarity bit, so a polarity of 0 gives an active-high pulse and a polarity of 1 gives an active-low pulse. The polarity bits are: `crt_hsync` at address 3 bit 7, `lcd_line` at address 3 bit 6, `crt_vsync` at address 8 bit 7, and `lcd_frame` at address 8 bit 6.
- R8: `vnd_status` is 1 exactly when `line_y` ≥ VA+1. The same value reads back as bit 7 of address 6, and writing that bit has no effect.
- R9: A field written mid-frame leaves the current frame's timing unchanged. It takes effect from the cycle in which both counters return to 0.
- R10: `rd_data` combinationally returns the last value written to `rd_addr`, with the bits outside that address's fields read as 0. The masks are: 0x7F, 0x1F, 0x1F, 0xCF, 0xFF, 0x03, 0x3F (plus the live status in bit 7), 0x3F and 0xC7. An address above 8 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Field address of the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Field address of the read |
| rd_data | output | 8 | Read data, combinational |
| pix_x | output | 12 | Pixel position in the line |
| line_y | output | 12 | Line position in the frame |
| de | output | 1 | Display enable |
| hblank | output | 1 | Horizontal non-display |
| vblank | output | 1 | Vertical non-display |
| crt_hsync | output | 1 | CRT horizontal sync |
| crt_vsync | output | 1 | CRT vertical sync |
| lcd_line | output | 1 | Panel line pulse |
| lcd_frame | output | 1 | Panel frame pulse |
| vnd_status | output | 1 | Vertical non-display flag |

## Verification
The assertions assume that `rst` is held across at least one clock edge before any check matters, and that fields change only through the write port. Under those conditions the live configuration moves only at a frame wrap, and both sync windows begin inside blanking. The stimulus programs a small frame: 16+24 pixels by 5+4 lines, later 32+24 pixels. Inputs are driven just after rising edges, and every output is compared on every falling edge against positions and windows computed arithmetically in the bench. Configuration changes are made both at quiet points and mid-frame, so the deferred-load rule is exercised at a real boundary.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam int HA_W = 7;
    localparam int HB_W = 5;
    localparam int HS_W = 5;
    localparam int HW_W = 4;
    localparam int VA_W = 10;
    localparam int VB_W = 6;
    localparam int VS_W = 6;
    localparam int VW_W = 3;

    localparam logic [ADDR_W-1:0] A_HACT   = 4'd0;
    localparam logic [ADDR_W-1:0] A_HBLK   = 4'd1;
    localparam logic [ADDR_W-1:0] A_HSOFF  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HSCTL  = 4'd3;
    localparam logic [ADDR_W-1:0] A_VACTLO = 4'd4;
    localparam logic [ADDR_W-1:0] A_VACTHI = 4'd5;
    localparam logic [ADDR_W-1:0] A_VBLK   = 4'd6;
    localparam logic [ADDR_W-1:0] A_VSOFF  = 4'd7;
    localparam logic [ADDR_W-1:0] A_VSCTL  = 4'd8;

    typedef enum logic [0:0] {
        SEG_ACTIVE = 1'b0,
        SEG_BLANK  = 1'b1
    } seg_state_e;

    typedef struct packed {
        logic [HA_W-1:0] h_act;
        logic [HB_W-1:0] h_blk;
        logic [HS_W-1:0] hs_off;
        logic [HW_W-1:0] hs_wid;
        logic            pol_crt_h;
        logic            pol_lcd_h;
        logic [VA_W-1:0] v_act;
        logic [VB_W-1:0] v_blk;
        logic [VS_W-1:0] vs_off;
        logic [VW_W-1:0] vs_wid;
        logic            pol_crt_v;
        logic            pol_lcd_v;
    } timing_cfg_t;

endpackage

// File: rtl/dtg_regfile.sv
`timescale 1ns/1ps
module dtg_regfile
    import dtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              frame_start,
    input  logic              vnd_flag,
    output logic [DATA_W-1:0] rd_data,
    output timing_cfg_t       live_cfg
);

    timing_cfg_t pend_q;
    timing_cfg_t live_q;

    // pending copy: written any time
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_HACT:   pend_q.h_act <= wr_data[HA_W-1:0];
                A_HBLK:   pend_q.h_blk <= wr_data[HB_W-1:0];
                A_HSOFF:  pend_q.hs_off <= wr_data[HS_W-1:0];
                A_HSCTL: begin
                    pend_q.hs_wid    <= wr_data[HW_W-1:0];
                    pend_q.pol_lcd_h <= wr_data[6];
                    pend_q.pol_crt_h <= wr_data[7];
                end
                A_VACTLO: pend_q.v_act[7:0] <= wr_data;
                A_VACTHI: pend_q.v_act[VA_W-1:8] <= wr_data[VA_W-9:0];
                A_VBLK:   pend_q.v_blk <= wr_data[VB_W-1:0];
                A_VSOFF:  pend_q.vs_off <= wr_data[VS_W-1:0];
                A_VSCTL: begin
                    pend_q.vs_wid    <= wr_data[VW_W-1:0];
                    pend_q.pol_lcd_v <= wr_data[6];
                    pend_q.pol_crt_v <= wr_data[7];
                end
                default: ;
            endcase
        end
    end

    // live copy: follows the pending copy only at a frame boundary
    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
        end else if (frame_start) begin
            live_q <= pend_q;
        end
    end

    assign live_cfg = live_q;

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_HACT:   rd_data[HA_W-1:0] = pend_q.h_act;
            A_HBLK:   rd_data[HB_W-1:0] = pend_q.h_blk;
            A_HSOFF:  rd_data[HS_W-1:0] = pend_q.hs_off;
            A_HSCTL:  rd_data = {pend_q.pol_crt_h, pend_q.pol_lcd_h, 2'b00, pend_q.hs_wid};
            A_VACTLO: rd_data = pend_q.v_act[7:0];
            A_VACTHI: rd_data[VA_W-9:0] = pend_q.v_act[VA_W-1:8];
            A_VBLK:   rd_data = {vnd_flag, 1'b0, pend_q.v_blk};
            A_VSOFF:  rd_data[VS_W-1:0] = pend_q.vs_off;
            A_VSCTL:  rd_data = {pend_q.pol_crt_v, pend_q.pol_lcd_v, 3'b000, pend_q.vs_wid};
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/dtg_axis.sv
`timescale 1ns/1ps
module dtg_axis
    import dtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic [CNT_W-1:0] act_len,
    input  logic [CNT_W-1:0] tot_len,
    output logic [CNT_W-1:0] pos,
    output seg_state_e       state,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seg_state_e       state_q, state_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic             at_act_end;
    logic             at_tot_end;

    assign at_act_end = (pos_q == act_len - ONE);
    assign at_tot_end = (pos_q == tot_len - ONE);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEG_ACTIVE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // next state: ACT_DONE and WRAP
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (step) begin
            unique case (state_q)
                SEG_ACTIVE: begin
                    pos_d = pos_q + ONE;
                    if (at_act_end) begin
                        state_d = SEG_BLANK;
                    end
                end
                SEG_BLANK: begin
                    if (at_tot_end) begin
                        pos_d   = '0;
                        state_d = SEG_ACTIVE;
                    end else begin
                        pos_d = pos_q + ONE;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pos   = pos_q;
        state = state_q;
        wrap  = step && (state_q == SEG_BLANK) && at_tot_end;
    end

endmodule

// File: rtl/dtg_pulse.sv
`timescale 1ns/1ps
module dtg_pulse #(
    parameter int CNT_W = 12
) (
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] begin_pos,
    input  logic [CNT_W-1:0] len,
    input  logic             pol_crt,
    input  logic             pol_lcd,
    output logic             window,
    output logic             crt_out,
    output logic             lcd_out
);

    logic [CNT_W:0] end_pos;

    assign end_pos = {1'b0, begin_pos} + {1'b0, len};

    always_comb begin
        window  = (pos >= begin_pos) && ({1'b0, pos} < end_pos);
        crt_out = window ^ pol_crt;
        lcd_out = window ^ pol_lcd;
    end

endmodule

// File: rtl/disp_timing_gen.sv
`timescale 1ns/1ps
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  line_y,
    output logic              de,
    output logic              hblank,
    output logic              vblank,
    output logic              crt_hsync,
    output logic              crt_vsync,
    output logic              lcd_line,
    output logic              lcd_frame,
    output logic              vnd_status
);

    localparam logic [CNT_W-1:0] UNIT8 = CNT_W'(8);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] PULL2 = CNT_W'(6);

    timing_cfg_t      cfg;
    seg_state_e       h_state, v_state;
    logic             h_wrap, v_wrap, frame_start;
    logic [CNT_W-1:0] h_pos, v_pos;
    logic [CNT_W-1:0] h_act_len, h_tot_len, hs_begin, hs_len;
    logic [CNT_W-1:0] v_act_len, v_tot_len, vs_begin, vs_len;
    logic             hs_win, vs_win;
    logic             hs_crt, hs_lcd, vs_crt, vs_lcd;

    assign frame_start = h_wrap && v_wrap;

    dtg_regfile regs_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .frame_start(frame_start),
        .vnd_flag   (v_state == SEG_BLANK),
        .rd_data    (rd_data),
        .live_cfg   (cfg)
    );

    // decoded lengths: horizontal in 8-pixel units, vertical in lines
    always_comb begin
        h_act_len = CNT_W'({cfg.h_act, 3'b000}) + UNIT8;
        h_tot_len = h_act_len + CNT_W'({cfg.h_blk, 3'b000}) + UNIT8;
        hs_begin  = h_act_len + CNT_W'({cfg.hs_off, 3'b000}) + PULL2;
        hs_len    = CNT_W'({cfg.hs_wid, 3'b000}) + UNIT8;
        v_act_len = CNT_W'(cfg.v_act) + ONE;
        v_tot_len = v_act_len + CNT_W'(cfg.v_blk) + ONE;
        vs_begin  = v_act_len + CNT_W'(cfg.vs_off) + ONE;
        vs_len    = CNT_W'(cfg.vs_wid) + ONE;
    end

    dtg_axis #(.CNT_W(CNT_W)) h_axis_i (
        .clk    (clk),
        .rst    (rst),
        .step   (1'b1),
        .act_len(h_act_len),
        .tot_len(h_tot_len),
        .pos    (h_pos),
        .state  (h_state),
        .wrap   (h_wrap)
    );

    dtg_axis #(.CNT_W(CNT_W)) v_axis_i (
        .clk    (clk),
        .rst    (rst),
        .step   (h_wrap),
        .act_len(v_act_len),
        .tot_len(v_tot_len),
        .pos    (v_pos),
        .state  (v_state),
        .wrap   (v_wrap)
    );

    dtg_pulse #(.CNT_W(CNT_W)) h_pulse_i (
        .pos      (h_pos),
        .begin_pos(hs_begin),
        .len      (hs_len),
        .pol_crt  (cfg.pol_crt_h),
        .pol_lcd  (cfg.pol_lcd_h),
        .window   (hs_win),
        .crt_out  (hs_crt),
        .lcd_out  (hs_lcd)
    );

    dtg_pulse #(.CNT_W(CNT_W)) v_pulse_i (
        .pos      (v_pos),
        .begin_pos(vs_begin),
        .len      (vs_len),
        .pol_crt  (cfg.pol_crt_v),
        .pol_lcd  (cfg.pol_lcd_v),
        .window   (vs_win),
        .crt_out  (vs_crt),
        .lcd_out  (vs_lcd)
    );

    always_comb begin
        pix_x      = h_pos;
        line_y     = v_pos;
        hblank     = (h_state == SEG_BLANK);
        vblank     = (v_state == SEG_BLANK);
        de         = (h_state == SEG_ACTIVE) && (v_state == SEG_ACTIVE);
        vnd_status = (v_state == SEG_BLANK);
        crt_hsync  = hs_crt;
        lcd_line   = hs_lcd;
        crt_vsync  = vs_crt;
        lcd_frame  = vs_lcd;
    end

endmodule

// File: rtl/disp_timing_gen_chk.sv
`timescale 1ns/1ps
module disp_timing_gen_chk
    import dtg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] pix_x,
    input logic [CNT_W-1:0] line_y,
    input logic             de,
    input logic             vnd_status,
    input logic             hs_win,
    input logic             vs_win,
    input seg_state_e       h_state,
    input timing_cfg_t      cfg
);

    assert_pix_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pix_x == '0) || (pix_x == $past(pix_x) + CNT_W'(1)));

    assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (pix_x != '0) |-> (line_y == $past(line_y)));

    assert_de_not_in_vnd_R4: assert property (@(posedge clk) disable iff (rst)
        de |-> !vnd_status);

    assert_hsync_in_hblank_R5: assert property (@(posedge clk) disable iff (rst)
        hs_win |-> (h_state == SEG_BLANK));

    assert_vsync_in_vnd_R6: assert property (@(posedge clk) disable iff (rst)
        vs_win |-> vnd_status);

    assert_vnd_rise_at_line_start_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(vnd_status) |-> (pix_x == '0));

    assert_cfg_frozen_in_frame_R9: assert property (@(posedge clk) disable iff (rst)
        ((pix_x != '0) || (line_y != '0)) |-> $stable(cfg));

endmodule

bind disp_timing_gen disp_timing_gen_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .pix_x     (pix_x),
    .line_y    (line_y),
    .de        (de),
    .vnd_status(vnd_status),
    .hs_win    (hs_win),
    .vs_win    (vs_win),
    .h_state   (h_state),
    .cfg       (cfg)
);

// File: tb/disp_timing_gen_tb_top.sv
`timescale 1ns/1ps
module disp_timing_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [3:0]  rd_addr = 4'd6;
    logic [7:0]  rd_data;
    logic [11:0] pix_x, line_y;
    logic        de, hblank, vblank, crt_hsync, crt_vsync, lcd_line, lcd_frame, vnd_status;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    int mx = 0;
    int my = 0;
    int lv [0:8];
    int pv [0:8];

    always #2 clk = ~clk;

    disp_timing_gen dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pix_x(pix_x), .line_y(line_y),
        .de(de), .hblank(hblank), .vblank(vblank), .crt_hsync(crt_hsync),
        .crt_vsync(crt_vsync), .lcd_line(lcd_line), .lcd_frame(lcd_frame),
        .vnd_status(vnd_status)
    );

    function automatic int fmask(input int a);
        case (a)
            0: return 'h7F; 1: return 'h1F; 2: return 'h1F; 3: return 'hCF;
            4: return 'hFF; 5: return 'h03; 6: return 'h3F; 7: return 'h3F;
            8: return 'hC7; default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (x=%0d y=%0d)", tag, act, exp, mx, my);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // per-cycle model and comparison
    always @(negedge clk) begin
        int hact, htot, hsb, hse, vact, vtot, vsb, vse;
        bit hw, fw, hwin, vwin;
        if (rst) begin
            mx = 0; my = 0;
            for (int i = 0; i < 9; i++) begin lv[i] = 0; pv[i] = 0; end
        end else begin
            hact = 8 * ((lv[0] & 'h7F) + 1);
            htot = hact + 8 * ((lv[1] & 'h1F) + 1);
            hsb  = hact + 8 * ((lv[2] & 'h1F) + 1) - 2;
            hse  = hsb + 8 * ((lv[3] & 'h0F) + 1);
            vact = (lv[4] | ((lv[5] & 3) << 8)) + 1;
            vtot = vact + (lv[6] & 'h3F) + 1;
            vsb  = vact + (lv[7] & 'h3F) + 1;
            vse  = vsb + (lv[8] & 7) + 1;
            if (mon_on) begin
                hwin = (mx >= hsb) && (mx < hse);
                vwin = (my >= vsb) && (my < vse);
                chk(pix_x == 12'(mx), "R2 pix_x", pix_x, mx);
                chk(line_y == 12'(my), "R3 line_y", line_y, my);
                chk(de == ((mx < hact) && (my < vact)), "R4 de", de, (mx < hact) && (my < vact));
                chk(hblank == (mx >= hact), "R4 hblank", hblank, mx >= hact);
                chk(vblank == (my >= vact), "R4 vblank", vblank, my >= vact);
                chk(crt_hsync == (hwin ^ lv[3][7]), "R5 R7 crt_hsync", crt_hsync, hwin ^ lv[3][7]);
                chk(lcd_line == (hwin ^ lv[3][6]), "R5 R7 lcd_line", lcd_line, hwin ^ lv[3][6]);
                chk(crt_vsync == (vwin ^ lv[8][7]), "R6 R7 crt_vsync", crt_vsync, vwin ^ lv[8][7]);
                chk(lcd_frame == (vwin ^ lv[8][6]), "R6 R7 lcd_frame", lcd_frame, vwin ^ lv[8][6]);
                chk(vnd_status == (my >= vact), "R8 vnd_status", vnd_status, my >= vact);
                if (rd_addr == 4'd6)
                    chk(rd_data[7] == (my >= vact), "R8 status readback", rd_data[7], my >= vact);
            end
            hw = (mx == htot - 1);
            fw = hw && (my == vtot - 1);
            if (hw) begin mx = 0; my = fw ? 0 : my + 1; end
            else mx = mx + 1;
            if (fw) for (int i = 0; i < 9; i++) lv[i] = pv[i];
            if (wr_en && wr_addr < 9) pv[wr_addr] = wr_data & fmask(int'(wr_addr));
        end
    end

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(pix_x == 0, "R1 pix_x", pix_x, 0);
        chk(line_y == 0, "R1 line_y", line_y, 0);
        chk(de == 1'b1, "R1 de", de, 1);
        chk(vnd_status == 1'b0, "R1 vnd_status", vnd_status, 0);
        chk(crt_hsync == 1'b0 && lcd_line == 1'b0, "R1 hpulses", crt_hsync | lcd_line, 0);
        chk(crt_vsync == 1'b0 && lcd_frame == 1'b0, "R1 vpulses", crt_vsync | lcd_frame, 0);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        mon_on = 1'b1;

        // R10: readback masks
        rd_addr = 4'd0; wr(0, 'hFF); @(negedge clk);
        chk(rd_data == 8'h7F, "R10 addr0", rd_data, 'h7F);
        rd_addr = 4'd3; wr(3, 'hFF); @(negedge clk);
        chk(rd_data == 8'hCF, "R10 addr3", rd_data, 'hCF);
        rd_addr = 4'd5; wr(5, 'hFF); @(negedge clk);
        chk(rd_data == 8'h03, "R10 addr5", rd_data, 'h03);
        rd_addr = 4'd8; wr(8, 'hFF); @(negedge clk);
        chk(rd_data == 8'hC7, "R10 addr8", rd_data, 'hC7);
        rd_addr = 4'd6; wr(6, 'hFF); @(negedge clk);
        chk(rd_data[6:0] == 7'h3F, "R10 addr6", rd_data[6:0], 'h3F);
        rd_addr = 4'd12; @(negedge clk);
        chk(rd_data == 8'h00, "R10 unmapped", rd_data, 0);
        rd_addr = 4'd6;

        // configuration A: 16+24 px, 5+4 lines
        wr(0, 1); wr(1, 2); wr(2, 0); wr(3, 'h80);
        wr(4, 4); wr(5, 0); wr(6, 3); wr(7, 0); wr(8, 'h41);
        repeat (1500) @(negedge clk);

        // R9: mid-frame change of the active width
        do @(negedge clk); while (!(line_y == 2 && pix_x == 5));
        wr(0, 3);
        do @(negedge clk); while (pix_x != 39);
        @(negedge clk);
        chk(pix_x == 0, "R9 old line length kept", pix_x, 0);
        repeat (1200) @(negedge clk);

        // configuration B: flipped polarities, wider pulses
        wr(3, 'h41); wr(8, 'h82);
        repeat (1100) @(negedge clk);

        // truncated windows at line and frame end
        wr(2, 1); wr(7, 1);
        repeat (1100) @(negedge clk);

        // R8: status bit write ignored
        do @(negedge clk); while (!(line_y == 0 && pix_x == 3));
        wr(6, 'h83);
        @(negedge clk);
        chk(rd_data[7] == 1'b0, "R8 status write ignored", rd_data[7], 0);
        chk(vnd_status == 1'b0, "R8 status port unaffected", vnd_status, 0);
        do @(negedge clk); while (line_y != 5);
        chk(rd_data[7] == 1'b1, "R8 status in vnd", rd_data[7], 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule